// File: doc/BRIEF.md
# Duty Ratio Calibration Sweeper

This block walks a PWM ratio value through a calibration sweep without any help from software. Once started, it holds the ratio at 1 for a fixed dwell, then steps it upward to 10000 and back down to 1. At the end of every dwell it raises a one-cycle record strobe while the ratio is still at the value that was held. Downstream logging logic uses that strobe to capture the ratio together with the voltage and current readings. The ratio output feeds a PWM generator directly.

The step grows with the magnitude of the ratio. This gives fine resolution where the output voltage changes quickly and coarse steps where it flattens out. The upward and downward passes use the same ranges, so both passes visit a near-identical set of points and the two measured curves can be compared. The dwell length is a cycle-count parameter. Its default gives 30 s at a 50 MHz clock, and a simulation can shrink it to a few cycles.

Top module: `duty_sweep_seq`

## Requirements
- R1: After reset, and while idle, `duty_x` is 1, `rec_stb` is 0 and `done` is 0.
- R2: A `start` pulse while idle begins the ascending pass in the next cycle. Every ratio value, including the first value of 1, is then held on `duty_x` for exactly DWELL_TICKS clock cycles.
- R3: The step is chosen from the value held before the change:
  - 1 for 1..20
  - 5 for 21..200
  - 20 for 201..1000
  - 100 for 1001..3000
  - 200 for 3001..5000
  - 500 for 5001..10000

  For example, the ascending pass runs 19, 20, 21, 26.
- R4: In the ascending pass, a sum above 10000 is clamped to 10000. After 10000 has been held once, the descending pass starts from 10000 minus its step, which is 9500.
- R5: The descending pass subtracts the step for the held value's range, for example 5000 goes to 4800 and 1000 goes to 980. A difference below 1 is clamped to 1.
- R6: `rec_stb` is high for exactly the last cycle of each dwell. `duty_x` still shows the held value in that cycle and takes the next value in the following cycle.
- R7: After the value 1 has been held in the descending pass, `done` rises in the next cycle. From then on, `duty_x` stays at 1 and no further strobes occur.
- R8: `abort` in any state returns the block to idle in the next cycle, with `duty_x` at 1, `done` at 0 and no strobe.
- R9: `start` has no effect while a sweep is in progress.
- R10: `start` while `done` is high clears `done` and begins a new sweep from 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep (from idle or done) |
| abort | input | 1 | Cancel and return to idle |
| duty_x | output | XW | Current PWM ratio value |
| rec_stb | output | 1 | One-cycle strobe at the end of each dwell |
| done | output | 1 | Sweep finished |

## Verification
The assertions assume that DWELL_TICKS is at least 2 and that XW is wide enough to hold 10000. This makes the strobe a single isolated cycle and keeps the ratio from wrapping. They also assume that `abort` is the only way the ratio can change outside a strobe cycle. The bench keeps to this by using a dwell of 3 cycles at the default width. It changes `start` and `abort` only on falling clock edges. It checks the whole sweep cycle by cycle against a sequence computed from the step ranges.

// File: rtl/duty_sweep_seq.sv
module duty_sweep_seq #(
  parameter int unsigned DWELL_TICKS = 1_500_000_000,
  parameter int          XW          = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  output logic [XW-1:0] duty_x,
  output logic          rec_stb,
  output logic          done
);
  localparam int CW = (DWELL_TICKS > 1) ? $clog2(DWELL_TICKS) : 1;
  localparam logic [XW-1:0] X_ONE = XW'(1);
  localparam logic [XW-1:0] X_TOP = XW'(10000);

  typedef enum logic [1:0] {S_IDLE, S_UP, S_DOWN, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [XW-1:0] step;
  logic [XW:0]   sum;
  logic [XW-1:0] up_nx, dn_nx;
  logic          running, last;

  always_comb begin
    if      (duty_x <= XW'(20))   step = XW'(1);
    else if (duty_x <= XW'(200))  step = XW'(5);
    else if (duty_x <= XW'(1000)) step = XW'(20);
    else if (duty_x <= XW'(3000)) step = XW'(100);
    else if (duty_x <= XW'(5000)) step = XW'(200);
    else                          step = XW'(500);
  end

  assign sum     = {1'b0, duty_x} + {1'b0, step};
  assign up_nx   = (sum > {1'b0, X_TOP}) ? X_TOP : sum[XW-1:0];
  assign dn_nx   = (duty_x > step) ? duty_x - step : X_ONE;
  assign running = (st == S_UP) || (st == S_DOWN);
  assign last    = (cnt == CW'(DWELL_TICKS - 1));
  assign rec_stb = running && last;
  assign done    = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      duty_x <= X_ONE;
    end else if (abort) begin
      st     <= S_IDLE;
      cnt    <= '0;
      duty_x <= X_ONE;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          st     <= S_UP;
          cnt    <= '0;
          duty_x <= X_ONE;
        end
        S_UP: if (last) begin
          cnt <= '0;
          if (duty_x == X_TOP) begin
            st     <= S_DOWN;
            duty_x <= dn_nx;
          end else begin
            duty_x <= up_nx;
          end
        end else cnt <= cnt + 1'b1;
        S_DOWN: if (last) begin
          cnt <= '0;
          if (duty_x == X_ONE) st <= S_DONE;
          else duty_x <= dn_nx;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/duty_sweep_seq_chk.sv
module duty_sweep_seq_chk #(
  parameter int XW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          abort,
  input logic [XW-1:0] duty_x,
  input logic          rec_stb,
  input logic          done
);
  AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    duty_x >= XW'(1) && duty_x <= XW'(10000)); // R4
  AST_REC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_stb |=> !rec_stb); // R6
  AST_HOLD_NO_REC: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_stb && !abort) |=> $stable(duty_x)); // R2
  AST_DONE_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (duty_x == XW'(1) && !rec_stb)); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (duty_x == XW'(1) && !done && !rec_stb)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !abort) |=> done); // R7
endmodule

bind duty_sweep_seq duty_sweep_seq_chk #(.XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
  .duty_x(duty_x), .rec_stb(rec_stb), .done(done)
);

// File: tb/duty_sweep_seq_bench.sv
module duty_sweep_seq_bench;
  localparam int D  = 3;
  localparam int XW = 14;

  logic clk = 0, rst_n = 0, start = 0, abort = 0;
  logic [XW-1:0] duty_x;
  logic rec_stb, done;
  int errors = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;

  duty_sweep_seq #(.DWELL_TICKS(D), .XW(XW)) u_duty_sweep_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .duty_x(duty_x), .rec_stb(rec_stb), .done(done)
  );

  function automatic int stp(int v);
    if (v <= 20) return 1;
    if (v <= 200) return 5;
    if (v <= 1000) return 20;
    if (v <= 3000) return 100;
    if (v <= 5000) return 200;
    return 500;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic idle_check(string req, int n);
    for (int i = 0; i < n; i++) begin
      chk(req, duty_x, 1); chk(req, rec_stb, 0); chk(req, done, 0);
      @(negedge clk);
    end
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic run_sweep(bit poke_start);
    int v = 1;
    bit down = 0;
    int seen_top = 0;
    forever begin
      for (int k = 0; k < D; k++) begin
        if (poke_start) start = (v == 26 && k == 1);
        chk(down ? "R5 value" : "R3 value", duty_x, v);
        chk("R6 strobe", rec_stb, (k == D - 1) ? 1 : 0);
        chk("R2 busy", done, 0);
        @(negedge clk);
      end
      start = 0;
      if (down && v == 1) break;
      if (!down) begin
        if (v == 10000) begin seen_top++; down = 1; v = v - stp(v); end
        else v = (v + stp(v) > 10000) ? 10000 : v + stp(v);
      end else v = (v > stp(v)) ? v - stp(v) : 1;
    end
    chk("R4 top held once", seen_top, 1);
    for (int i = 0; i < 2 * D; i++) begin
      chk("R7 done", done, 1); chk("R7 x", duty_x, 1); chk("R7 strobe", rec_stb, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset x", duty_x, 1);
    chk("R1 reset strobe", rec_stb, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1;
    @(negedge clk);
    idle_check("R1 idle", 4);
    pulse_start();
    run_sweep(1);          // R2 R3 R4 R5 R6 R7 R9
    pulse_start();         // R10
    chk("R10 done cleared", done, 0);
    for (int i = 0; i < 5 * D + 1; i++) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    idle_check("R8 abort", 3 * D);
    pulse_start();
    for (int i = 0; i < 20 * D; i++) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    idle_check("R8 abort late", 2 * D);
    pulse_start();
    run_sweep(0);          // R10 full restart
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d expected below %0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule